// File: doc/BRIEF.md
# Running-Disparity Word-Inversion Lane Encoder

This block is the transmit-side encoder for one serial data lane and its companion frame clock lane. On each frame it takes a 7-bit parallel word, decides from the sign of the lane's running digital sum whether to send that word as it is or bitwise inverted, and then sends a 9-bit frame. The frame is the 7 data bits followed by two complementary marker bits that record the choice. The running digital sum adds +1 for every 1 driven onto the lane and −1 for every 0.

Every register advances only on cycles where the bit-rate enable `en` is high. One frame takes nine enabled cycles. The block raises `load_o` in the enabled cycle where it samples `din`, and the first bit of that frame appears on `ser_o` after the next enabled edge. A second output, `fclk_o`, carries a frame-rate clock that is high at the start of each frame. Its high time alternates between 4 and 5 bit times, so the clock lane also stays balanced. A receiver can recover the word by inverting the data bits whenever the first marker bit is 1.

Top module: `dcb_lane_encoder`

## Requirements
- R1: `load_o` is high exactly in the enabled cycles where the internal bit position is the last of the frame, which is once every 9 enabled cycles. After reset the first enabled cycle is such a cycle. `din` is sampled when `load_o` is high, and frame bit 0 appears on `ser_o` after that same clock edge.
- R2: The word is sent inverted when its disparity (2·ones − 7) has the same sign as the running sum at the word boundary and the running sum is nonzero. In every other case, including a running sum of exactly zero, it is sent unchanged.
- R3: Frame bits leave in this order: positions 0–6 carry the word (inverted or not), least significant bit first. Position 7 is 1 when the word was inverted and 0 otherwise. Position 8 is always the complement of position 7.
- R4: The running sum starts at zero after reset and counts all 9 transmitted bits, markers included. Measured at every frame boundary, the running sum of `ser_o` stays within −7 to +7.
- R5: `fclk_o` is high for the first 4 bit times of the first frame after reset, then low until the frame ends. After that, frames alternate between a high time of 5 and a high time of 4, with the high part always at the start of the frame.
- R6: Counted from the first frame, the running sum of `fclk_o` stays within −1 to +4, so its peak-to-peak excursion is at most 5.
- R7: In a cycle where `en` is low, the edge that follows changes neither `ser_o` nor `fclk_o`, `load_o` is low, and `din` is ignored.
- R8: While reset is asserted, `ser_o`, `fclk_o` and `load_o` (with `en` low) are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Bit-rate enable; all state advances only when high |
| din | input | DATA_W (7) | Parallel word, sampled while `load_o` is high |
| load_o | output | 1 | Frame-start strobe: word is captured this cycle |
| ser_o | output | 1 | Serial data lane, one frame bit per enabled cycle |
| fclk_o | output | 1 | Frame clock lane with alternating 4/5 high times |

## Verification
The embedded assertions check four things on every cycle: the stored running sum stays within its boundary bound, a positive or negative sum always moves back toward zero after a load, the marker pair always differs on the line, and a low enable freezes both lanes. They also track the clock lane's running sum and check the alternating high-time phase. Some behaviour only the bench's scenarios can show: that the inversion decision matches the rule word by word, that the zero-sum tie sends the word unchanged, and that frame and bit order survive irregular enable patterns and a reset in mid-frame. For these, a behavioural reference model in the bench is compared with every output on every clock, across runs of all-ones, all-zeros, alternating and random words.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  localparam int MARK_W = 2;

  typedef enum logic {
    HI_SHORT = 1'b0,
    HI_LONG  = 1'b1
  } clk_phase_e;
endpackage

// File: rtl/dcb_frame_timer.sv
module dcb_frame_timer #(
  parameter int FRAME_W = 9,
  localparam int IDX_W = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [IDX_W-1:0] idx_o,
  output logic             load_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_W - 1);

  logic [IDX_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LAST;
    else        cnt_q <= cnt_d;
  end

  assign idx_o  = cnt_q;
  assign load_o = en && (cnt_q == LAST);

  AST_ONE_LOAD_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o); // R1
endmodule

// File: rtl/dcb_balance_ctl.sv
module dcb_balance_ctl #(
  parameter int DATA_W = 7,
  parameter int FRAME_W = DATA_W + 2,
  localparam int POP_W = $clog2(FRAME_W + 1),
  localparam int RDS_W = POP_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [DATA_W-1:0]  word_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic signed [RDS_W-1:0] rds_q, rds_d;
  logic signed [RDS_W-1:0] word_disp, sent_disp;
  logic [POP_W-1:0]        word_pop, frame_pop;
  logic                    inv;

  always_comb begin
    word_pop = '0;
    for (int i = 0; i < DATA_W; i++) word_pop = word_pop + POP_W'(word_i[i]);
    word_disp = RDS_W'({word_pop, 1'b0}) - RDS_W'(DATA_W);
  end

  // invert only when the word would push the sum further from zero
  always_comb begin
    inv = (rds_q != 0) && (word_disp != 0) && ((word_disp > 0) == (rds_q > 0));
    frame_o = {~inv, inv, (inv ? ~word_i : word_i)};
  end

  always_comb begin
    frame_pop = '0;
    for (int i = 0; i < FRAME_W; i++) frame_pop = frame_pop + POP_W'(frame_o[i]);
    sent_disp = RDS_W'({frame_pop, 1'b0}) - RDS_W'(FRAME_W);
    rds_d = rds_q;
    if (load_i) rds_d = rds_q + sent_disp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rds_q <= '0;
    else        rds_q <= rds_d;
  end

  AST_RDS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (rds_q >= -RDS_W'(DATA_W)) && (rds_q <= RDS_W'(DATA_W))); // R4
  AST_PULL_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && rds_q > 0) |=> (rds_q < $past(rds_q))); // R2
  AST_PULL_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && rds_q < 0) |=> (rds_q > $past(rds_q))); // R2
endmodule

// File: rtl/dcb_shifter.sv
module dcb_shifter #(
  parameter int FRAME_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               ser_o
);
  logic [FRAME_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load_i)  sh_d = frame_i;
    else if (en) sh_d = sh_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign ser_o = sh_q[0];
endmodule

// File: rtl/dcb_clk_lane.sv
module dcb_clk_lane
  import dcb_pkg::*;
#(
  parameter int FRAME_W = 9,
  parameter int SHORT_HI = 4,
  localparam int IDX_W = $clog2(FRAME_W),
  localparam int CS_W = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             fclk_o
);
  clk_phase_e phase_q, phase_d;
  logic [IDX_W-1:0] hi_len;

  always_comb begin
    phase_d = phase_q;
    if (load_i) phase_d = (phase_q == HI_LONG) ? HI_SHORT : HI_LONG;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= HI_LONG;
    else        phase_q <= phase_d;
  end

  assign hi_len = (phase_q == HI_LONG) ? IDX_W'(SHORT_HI + 1) : IDX_W'(SHORT_HI);
  assign fclk_o = (idx_i < hi_len);

  // running-sum tracker for the clock lane, active from the first frame
  logic                   run_q;
  logic signed [CS_W-1:0] csum_q, csum_d, step;

  always_comb begin
    step   = fclk_o ? CS_W'(1) : -CS_W'(1);
    csum_d = csum_q;
    if (en && run_q) csum_d = csum_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      csum_q <= '0;
    end else begin
      csum_q <= csum_d;
      if (load_i) run_q <= 1'b1;
    end
  end

  AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (phase_q != $past(phase_q))); // R5
  AST_CLK_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (csum_q >= -CS_W'(1)) && (csum_q <= CS_W'(SHORT_HI))); // R6
endmodule

// File: rtl/dcb_lane_encoder.sv
module dcb_lane_encoder
  import dcb_pkg::*;
#(
  parameter int DATA_W = 7,
  parameter int SHORT_HI = 4,
  localparam int FRAME_W = DATA_W + MARK_W,
  localparam int IDX_W = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic              load_o,
  output logic              ser_o,
  output logic              fclk_o
);
  logic [IDX_W-1:0]   idx;
  logic [FRAME_W-1:0] frame;

  dcb_frame_timer #(.FRAME_W(FRAME_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .idx_o(idx), .load_o(load_o)
  );

  dcb_balance_ctl #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .load_i(load_o), .word_i(din), .frame_o(frame)
  );

  dcb_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(en), .load_i(load_o), .frame_i(frame),
    .ser_o(ser_o)
  );

  dcb_clk_lane #(.FRAME_W(FRAME_W), .SHORT_HI(SHORT_HI)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(en), .load_i(load_o), .idx_i(idx),
    .fclk_o(fclk_o)
  );

  AST_MARK_PAIR_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
    ((idx == IDX_W'(FRAME_W - 1)) && ($past(idx) == IDX_W'(FRAME_W - 2)))
      |-> (ser_o != $past(ser_o))); // R3
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(ser_o) && $stable(fclk_o))); // R7
endmodule

// File: tb/dcb_lane_encoder_tb.sv
module dcb_lane_encoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [6:0] din = '0;
  logic       load_o, ser_o, fclk_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int       m_idx, m_rds, d_sum, c_sum;
  bit       m_long, m_run, m_ser;
  bit [8:0] m_bits;

  always #5 clk = ~clk;

  dcb_lane_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din),
    .load_o(load_o), .ser_o(ser_o), .fclk_o(fclk_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic chk_range(input string tag, input int v, input int lo, input int hi);
    checks++;
    if (v < lo || v > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=[%0d..%0d]", tag, v, lo, hi);
    end
  endtask

  task automatic model_reset();
    m_idx = 8; m_rds = 0; m_long = 1'b1; m_run = 1'b0; m_ser = 1'b0;
    m_bits = '0; d_sum = 0; c_sum = 0;
  endtask

  task automatic step(input bit e, input logic [6:0] d);
    int w;
    bit inv, exp_fclk, was_load;
    @(negedge clk);
    en = e; din = d;
    #1;
    chk("R1 load strobe", int'(load_o), int'(e && m_idx == 8));
    was_load = 1'b0;
    if (e) begin
      if (m_idx == 8) begin
        w = 2 * $countones(d) - 7;
        inv = (m_rds != 0) && ((w > 0) == (m_rds > 0));
        m_bits = {~inv, inv, (inv ? ~d : d)};
        m_rds = m_rds + (inv ? -w : w);
        m_idx = 0;
        m_long = ~m_long;
        was_load = 1'b1;
      end else begin
        m_idx++;
      end
      if (m_run || was_load) m_ser = m_bits[m_idx];
    end
    @(posedge clk);
    #2;
    exp_fclk = (m_idx < (m_long ? 5 : 4));
    if (!e) begin
      chk("R7 ser hold", int'(ser_o), int'(m_ser));
      chk("R7 fclk hold", int'(fclk_o), int'(exp_fclk));
    end else begin
      if (m_idx < 7) chk("R2 data bit", int'(ser_o), int'(m_ser));
      else           chk("R3 marker bit", int'(ser_o), int'(m_ser));
      chk("R5 frame clock", int'(fclk_o), int'(exp_fclk));
      if (m_run || was_load) begin
        if (m_idx == 0) chk_range("R4 boundary sum", d_sum, -7, 7);
        d_sum += ser_o ? 1 : -1;
        c_sum += fclk_o ? 1 : -1;
        chk_range("R6 clock sum", c_sum, -1, 4);
      end
    end
    if (was_load) m_run = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0;
    model_reset();
    @(negedge clk); @(negedge clk);
    chk("R8 ser in reset", int'(ser_o), 0);
    chk("R8 fclk in reset", int'(fclk_o), 0);
    chk("R8 load in reset", int'(load_o), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    // random words, continuous enable
    for (int i = 0; i < 540; i++) step(1'b1, 7'($urandom));
    // random words with an irregular enable
    for (int i = 0; i < 900; i++) step(($urandom % 10) < 7, 7'($urandom));
    // all ones: forces alternate inversion (R2)
    for (int i = 0; i < 180; i++) step(1'b1, 7'h7F);
    // all zeros
    for (int i = 0; i < 180; i++) step(1'b1, 7'h00);
    // alternating patterns, disparities +1 and -1
    for (int i = 0; i < 360; i++) step(1'b1, ((i / 9) % 2) ? 7'h55 : 7'h2A);
    // single-one words keep the sum near zero (tie case of R2)
    for (int i = 0; i < 270; i++) step(1'b1, 7'(1 << ((i / 9) % 7)));
    // reset in mid-frame, then resume
    for (int i = 0; i < 13; i++) step(1'b1, 7'($urandom));
    do_reset();
    for (int i = 0; i < 600; i++) step(($urandom % 4) != 0, 7'($urandom));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule